// File: doc/BRIEF.md
# Multiply-Accumulate Accumulator Repacker

This block keeps four 48-bit accumulators and a 16-bit mode/status register for a multiply-accumulate unit. Each accumulator stores three fields: a 32-bit core and two 8-bit extension bytes. Where the core and the lower extension byte sit depends on the arithmetic mode held in the status register. A write that changes the fractional-mode bit or the signed-mode bit therefore does more than store a register. It re-lays out every accumulator in the layout the new mode uses.

Each field is read out of an accumulator using the old mode, then packed back using the new mode. This is done one accumulator per clock, in ascending index order. While this runs, `busy` is high, the status write port reports not-ready, and direct accumulator loads are dropped. The new status value becomes visible only after all four accumulators have been rewritten. A status write that leaves both mode bits unchanged is stored on the next edge and no repack takes place. The multiply-accumulate datapath is not part of this block. It uses the load port and the read port.

Top module: `macAccRepacker`

## Requirements
- R1: After reset, all accumulators read zero and the status register reads zero, which means integer, unsigned mode. `busy` is low and `csrWrReady` is high.
- R2: While `busy` is low, a direct load writes `accLoadData` into accumulator `accLoadIdx` on the clock edge. The read port returns accumulator `accRdIdx` combinationally.
- R3: An accepted status write whose bit 5 and bit 6 both match the stored value is visible on the next edge. It raises no `busy` and leaves every accumulator unchanged.
- R4: An accepted status write that changes bit 5 or bit 6 raises `busy` for exactly four cycles. The old status value stays visible throughout, and the new value appears on the edge where `busy` falls.
- R5: Fields are read out using the old mode. The upper byte is always in bits 47:40. In fractional mode (bit 5 = 1) the core is in bits 39:8 and the lower byte in bits 7:0. In integer mode (bit 5 = 0) the core is in bits 31:0 and the lower byte in bits 39:32.
- R6: Packing for fractional mode places {upper, core, lower} in bits 47:40, 39:8 and 7:0.
- R7: Packing for unsigned integer mode (bit 5 = 0, bit 6 = 0) places {upper, lower, core} in bits 47:40, 39:32 and 31:0, with both bytes zero-extended.
- R8: Packing for signed integer mode (bit 5 = 0, bit 6 = 1) treats the lower byte as signed. When lower-byte bit 7 is set, its sign fill is ORed into bits 47:40 over the upper byte.
- R9: While `busy` is high, `csrWrReady` is low. Status writes and direct loads presented during that time are ignored.
- R10: A change of the signed bit alone starts a full four-cycle repack, including while fractional mode stays selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrWrEn | input | 1 | Status register write request |
| csrWrData | input | 16 | Status value to write (bit 5 fractional, bit 6 signed) |
| csrWrReady | output | 1 | High when a status write is accepted |
| csrValue | output | 16 | Current status register value |
| busy | output | 1 | Repack in progress |
| accLoadEn | input | 1 | Direct accumulator load strobe |
| accLoadIdx | input | 2 | Accumulator to load |
| accLoadData | input | 48 | Load value |
| accRdIdx | input | 2 | Accumulator to read |
| accRdData | output | 48 | Selected accumulator contents |

## Verification
The bench builds the block with its default parameters: four accumulators, a 32-bit core and 8-bit extension bytes. At this size every ordered pair of the four modes can be swept. All twelve mode transitions are exercised, each on freshly loaded accumulators whose lower bytes include values with bit 7 set and clear. This reaches every combination of old-mode extraction and new-mode packing, including the sign fill in signed integer mode. Expected accumulator values come from shift-and-mask arithmetic in the bench. Separate passes cover writes that change no mode bit, a signed-bit-only change under fractional mode, and writes and loads presented during a repack.

// File: rtl/macRepackPkg.sv
package macRepackPkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic storeDirect;  // status write with no mode change
    logic captureNew;   // mode-changing write: hold new value
    logic stepEn;       // repack one accumulator this cycle
    logic commit;       // last step: publish the held status value
  } repackCtl_t;

endpackage

// File: rtl/macRepackCtrl.sv
module macRepackCtrl
  import macRepackPkg::*;
#(
  parameter int NUM_ACC = 4,
  localparam int IDX_W = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csrWrEn,
  input  logic [1:0]       wrMode,   // {signed, fractional} of incoming write
  input  logic [1:0]       curMode,  // {signed, fractional} currently stored
  output repackCtl_t       ctl,
  output logic [IDX_W-1:0] stepIdx,
  output logic             busy,
  output logic             ready
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ACC - 1);

  logic             busyQ;
  logic [IDX_W-1:0] cntQ;
  logic             accept;
  logic             modeDiff;

  assign accept   = csrWrEn && !busyQ;
  assign modeDiff = |(wrMode ^ curMode);

  always_comb begin
    ctl.storeDirect = accept && !modeDiff;
    ctl.captureNew  = accept && modeDiff;
    ctl.stepEn      = busyQ;
    ctl.commit      = busyQ && (cntQ == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (ctl.captureNew) begin
      busyQ <= 1'b1;
      cntQ  <= '0;
    end else if (busyQ) begin
      if (cntQ == LAST_IDX) begin
        busyQ <= 1'b0;
        cntQ  <= '0;
      end else begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  assign stepIdx = cntQ;
  assign busy    = busyQ;
  assign ready   = !busyQ;

  // A repack only ever starts from a write request.
  assert_busy_origin_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(csrWrEn));

  // A write that keeps both mode bits never starts a repack.
  assert_plain_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.storeDirect |=> !busyQ);

  // A request seen while busy does not restart the step count.
  assert_stall_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && csrWrEn && cntQ != LAST_IDX) |=> (cntQ == $past(cntQ) + 1'b1));

endmodule

// File: rtl/macRepackDp.sv
module macRepackDp
  import macRepackPkg::*;
#(
  parameter int NUM_ACC  = 4,
  parameter int CORE_W   = 32,
  parameter int EXT_W    = 8,
  parameter int CSR_W    = 16,
  parameter int FRAC_BIT = 5,
  parameter int SIGN_BIT = 6,
  localparam int ACC_W = CORE_W + 2 * EXT_W,
  localparam int IDX_W = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  repackCtl_t       ctl,
  input  logic [IDX_W-1:0] stepIdx,
  input  logic             busy,
  input  logic [CSR_W-1:0] csrWrData,
  input  logic             accLoadEn,
  input  logic [IDX_W-1:0] accLoadIdx,
  input  logic [ACC_W-1:0] accLoadData,
  input  logic [IDX_W-1:0] accRdIdx,
  output logic [ACC_W-1:0] accRdData,
  output logic [CSR_W-1:0] csrValue
);

  logic [CSR_W-1:0] csrQ;
  logic [CSR_W-1:0] pendQ;
  logic [ACC_W-1:0] accQ [NUM_ACC];
  logic [ACC_W-1:0] stepSrc;
  logic [ACC_W-1:0] stepRes;

  // Unpack with the old layout, pack with the new one.
  function automatic logic [ACC_W-1:0] repack(
    input logic [ACC_W-1:0] v,
    input logic             oldFrac,
    input logic             newFrac,
    input logic             newSign
  );
    logic [EXT_W-1:0]  hi;
    logic [EXT_W-1:0]  lo;
    logic [EXT_W-1:0]  top;
    logic [CORE_W-1:0] core;
    hi = v[ACC_W-1 -: EXT_W];
    if (oldFrac) begin
      core = v[EXT_W +: CORE_W];
      lo   = v[EXT_W-1:0];
    end else begin
      core = v[CORE_W-1:0];
      lo   = v[CORE_W +: EXT_W];
    end
    if (newFrac) begin
      return {hi, core, lo};
    end
    top = newSign ? (hi | {EXT_W{lo[EXT_W-1]}}) : hi;
    return {top, lo, core};
  endfunction

  assign stepSrc = accQ[stepIdx];
  assign stepRes = repack(stepSrc, csrQ[FRAC_BIT], pendQ[FRAC_BIT], pendQ[SIGN_BIT]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csrQ  <= '0;
      pendQ <= '0;
    end else begin
      if (ctl.storeDirect) csrQ <= csrWrData;
      if (ctl.captureNew)  pendQ <= csrWrData;
      if (ctl.commit)      csrQ <= pendQ;
    end
  end

  for (genvar g = 0; g < NUM_ACC; g++) begin : gAcc
    always_ff @(posedge clk) begin
      if (!rstN) begin
        accQ[g] <= '0;
      end else if (ctl.stepEn && stepIdx == IDX_W'(g)) begin
        accQ[g] <= stepRes;
      end else if (accLoadEn && !busy && accLoadIdx == IDX_W'(g)) begin
        accQ[g] <= accLoadData;
      end
    end
  end

  assign accRdData = accQ[accRdIdx];
  assign csrValue  = csrQ;

  // The held value is what becomes visible after the last step.
  assert_commit_value_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |=> (csrQ == $past(pendQ)));

  // Steps only run while the held mode differs from the stored one.
  assert_step_mode_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepEn |-> ((pendQ[FRAC_BIT] != csrQ[FRAC_BIT]) || (pendQ[SIGN_BIT] != csrQ[SIGN_BIT])));

  // The status register is frozen between capture and commit.
  assert_csr_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ctl.commit) |=> $stable(csrQ));

endmodule

// File: rtl/macAccRepacker.sv
module macAccRepacker
  import macRepackPkg::*;
#(
  parameter int NUM_ACC  = 4,
  parameter int CORE_W   = 32,
  parameter int EXT_W    = 8,
  parameter int CSR_W    = 16,
  parameter int FRAC_BIT = 5,
  parameter int SIGN_BIT = 6,
  localparam int ACC_W = CORE_W + 2 * EXT_W,
  localparam int IDX_W = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csrWrEn,
  input  logic [CSR_W-1:0] csrWrData,
  output logic             csrWrReady,
  output logic [CSR_W-1:0] csrValue,
  output logic             busy,
  input  logic             accLoadEn,
  input  logic [IDX_W-1:0] accLoadIdx,
  input  logic [ACC_W-1:0] accLoadData,
  input  logic [IDX_W-1:0] accRdIdx,
  output logic [ACC_W-1:0] accRdData
);

  repackCtl_t       ctl;
  logic [IDX_W-1:0] stepIdx;
  logic [1:0]       wrMode;
  logic [1:0]       curMode;

  assign wrMode  = {csrWrData[SIGN_BIT], csrWrData[FRAC_BIT]};
  assign curMode = {csrValue[SIGN_BIT], csrValue[FRAC_BIT]};

  macRepackCtrl #(.NUM_ACC(NUM_ACC)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .csrWrEn (csrWrEn),
    .wrMode  (wrMode),
    .curMode (curMode),
    .ctl     (ctl),
    .stepIdx (stepIdx),
    .busy    (busy),
    .ready   (csrWrReady)
  );

  macRepackDp #(
    .NUM_ACC(NUM_ACC), .CORE_W(CORE_W), .EXT_W(EXT_W),
    .CSR_W(CSR_W), .FRAC_BIT(FRAC_BIT), .SIGN_BIT(SIGN_BIT)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .stepIdx     (stepIdx),
    .busy        (busy),
    .csrWrData   (csrWrData),
    .accLoadEn   (accLoadEn),
    .accLoadIdx  (accLoadIdx),
    .accLoadData (accLoadData),
    .accRdIdx    (accRdIdx),
    .accRdData   (accRdData),
    .csrValue    (csrValue)
  );

  // The end of a repack always publishes a different status value.
  assert_publish_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (csrValue != $past(csrValue)));

endmodule

// File: tb/sim_macAccRepacker.sv
`timescale 1ns/1ps
module sim_macAccRepacker;

  logic        clk = 1'b0;
  logic        rstN;
  logic        csrWrEn;
  logic [15:0] csrWrData;
  logic        csrWrReady;
  logic [15:0] csrValue;
  logic        busy;
  logic        accLoadEn;
  logic [1:0]  accLoadIdx;
  logic [47:0] accLoadData;
  logic [1:0]  accRdIdx;
  logic [47:0] accRdData;

  int testCount = 0;
  int failCount = 0;
  logic [47:0] expAcc [4];
  logic [15:0] curCsr;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  macAccRepacker u0 (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrWrData(csrWrData),
    .csrWrReady(csrWrReady), .csrValue(csrValue), .busy(busy),
    .accLoadEn(accLoadEn), .accLoadIdx(accLoadIdx), .accLoadData(accLoadData),
    .accRdIdx(accRdIdx), .accRdData(accRdData)
  );

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // Arithmetic model of one repack step.
  function automatic logic [47:0] model(input logic [47:0] v, input logic oldFrac,
                                        input logic newFrac, input logic newSign);
    logic [47:0] hi, lo, core, r;
    hi = (v >> 40) & 48'hFF;
    if (oldFrac) begin
      core = (v >> 8) & 48'hFFFF_FFFF;
      lo   = v & 48'hFF;
    end else begin
      core = v & 48'hFFFF_FFFF;
      lo   = (v >> 32) & 48'hFF;
    end
    if (newFrac) r = (hi << 40) | (core << 8) | lo;
    else begin
      r = (hi << 40) | (lo << 32) | core;
      if (newSign && lo >= 48'd128) r = r | (48'hFF << 40);
    end
    return r;
  endfunction

  task automatic checkAccs(input string req);
    for (int i = 0; i < 4; i++) begin
      accRdIdx = 2'(i);
      #1;
      check(req, accRdData, expAcc[i]);
    end
  endtask

  task automatic loadAcc(input int idx, input logic [47:0] val);
    @(negedge clk);
    accLoadEn = 1'b1; accLoadIdx = 2'(idx); accLoadData = val;
    @(negedge clk);
    accLoadEn = 1'b0;
    expAcc[idx] = val;
  endtask

  task automatic csrWrite(input logic [15:0] val, input string accTag, input string busyTag);
    logic chg;
    int n;
    chg = ((val ^ curCsr) & 16'h0060) != 16'h0;
    @(negedge clk);
    check("R1 R9 ready before write", {47'd0, csrWrReady}, 48'd1);
    csrWrEn = 1'b1; csrWrData = val;
    @(negedge clk);
    csrWrEn = 1'b0;
    if (chg) begin
      check("R4 busy after mode write", {47'd0, busy}, 48'd1);
      check("R4 old status held", {32'd0, csrValue}, {32'd0, curCsr});
      n = 0;
      while (busy && n < 20) begin n++; @(negedge clk); end
      check(busyTag, 48'(n), 48'd4);
      for (int i = 0; i < 4; i++)
        expAcc[i] = model(expAcc[i], curCsr[5], val[5], val[6]);
    end else begin
      check("R3 no busy on plain write", {47'd0, busy}, 48'd0);
    end
    curCsr = val;
    check("R3 R4 status value", {32'd0, csrValue}, {32'd0, val});
    checkAccs(accTag);
  endtask

  function automatic logic [15:0] modeCsr(input int m, input logic [15:0] other);
    return (other & 16'hFF9F) | (16'(m & 1) << 5) | (16'((m >> 1) & 1) << 6);
  endfunction

  function automatic string packTag(input int m);
    if ((m & 1) != 0) return "R5 R6 fractional pack";
    if ((m & 2) != 0) return "R5 R8 signed pack";
    return "R5 R7 unsigned pack";
  endfunction

  initial begin
    int wd = 0;
    while (wd < 100000) begin @(posedge clk); wd++; end
    failCount++;
    testCount++;
    $display("FAIL R4 watchdog expired actual=%0d expected=<100000", wd);
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    rstN = 1'b0; csrWrEn = 1'b0; csrWrData = '0; accLoadEn = 1'b0;
    accLoadIdx = '0; accLoadData = '0; accRdIdx = '0;
    curCsr = '0;
    for (int i = 0; i < 4; i++) expAcc[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 status after reset", {32'd0, csrValue}, 48'd0);
    check("R1 busy after reset", {47'd0, busy}, 48'd0);
    check("R1 ready after reset", {47'd0, csrWrReady}, 48'd1);
    checkAccs("R1 accumulator after reset");

    // R2 direct loads and read back
    loadAcc(0, 48'h80_1234_5678_9A);
    loadAcc(1, 48'h7F_00FF_00FF_01);
    loadAcc(2, 48'hFF_FFFF_FFFF_FF);
    loadAcc(3, 48'h01_8000_0000_80);
    checkAccs("R2 load read back");

    // R3 writes that keep both mode bits
    csrWrite(16'h8F1F, "R3 accumulators untouched", "R3 unused");
    csrWrite(16'h0080, "R3 accumulators untouched", "R3 unused");

    // Sweep all ordered mode pairs on fresh data
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        if (a == b) continue;
        if (((curCsr >> 5) & 16'h3) != 16'(a))
          csrWrite(modeCsr(a, 16'(nextRand())), packTag(a), "R4 busy length setup");
        for (int i = 0; i < 4; i++) begin
          logic [47:0] v;
          v = {nextRand(), nextRand()} >> 16;
          if (i == 1) v[39] = 1'b1;  // lower byte negative in integer layout
          if (i == 2) v[7]  = 1'b1;  // lower byte negative in fractional layout
          if (i == 3) v[39] = 1'b0;
          loadAcc(i, v);
        end
        csrWrite(modeCsr(b, 16'(nextRand())), packTag(b),
                 ((a & 1) == (b & 1)) ? "R10 sign-only repack length" : "R4 busy length");
      end
    end

    // R9 stall: writes and loads during a repack are dropped
    loadAcc(0, 48'h12_3456_789A_BC);
    begin
      logic [15:0] tgt;
      tgt = modeCsr(((curCsr >> 5) & 1) != 0 ? 0 : 1, 16'h4321);
      @(negedge clk);
      csrWrEn = 1'b1; csrWrData = tgt;
      @(negedge clk);
      csrWrData = 16'hFFFF;  // still requesting while busy
      accLoadEn = 1'b1; accLoadIdx = 2'd2; accLoadData = 48'hDEAD_BEEF_0000;
      check("R9 ready low while busy", {47'd0, csrWrReady}, 48'd0);
      @(negedge clk);
      csrWrEn = 1'b0; accLoadEn = 1'b0;
      for (int i = 0; i < 4; i++)
        expAcc[i] = model(expAcc[i], curCsr[5], tgt[5], tgt[6]);
      while (busy) @(negedge clk);
      curCsr = tgt;
      check("R9 stalled write ignored", {32'd0, csrValue}, {32'd0, tgt});
      checkAccs("R9 stalled load ignored");
    end

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule